// File: doc/BRIEF.md
# Toggle-Polled Flash Sector Eraser

This block erases a contiguous run of sectors in a parallel NOR flash that takes unlock-cycle commands. For each sector in the range it sends a six-write command sequence: two unlock writes, an erase-setup write, two more unlock writes, and a sector-erase write to that sector's base. It then polls a status byte until the erase completes. Completion is found by reading status repeatedly and comparing bit 6 of two successive reads. While that bit keeps flipping, the device is still busy. Once it holds still, the sector is finished.

When bit 6 is still flipping and bit 5 is set, the block can take a second opinion, if that check is enabled. It takes two extra status reads. If bit 6 still flips between them, the erase has failed. If it does not, the erase only finished late. Between busy reads the block idles for a fixed poll gap of `POLL_GAP` cycles. A caller-supplied budget limits how many busy reads may be seen before the sector is declared stuck.

Every exit drives a final reset write to the bank base, except the rejection of an invalid range. Sector addresses come from a per-sector offset table added to the bank base. The block talks to the flash over a simple request/acknowledge bus with one transfer outstanding at a time.

Top module: `sector_eraser`

## Requirements
- R1: For each sector, the block writes these six bytes in order: 0xAA to unlock-A, 0x55 to unlock-B, 0x80 to unlock-A, 0xAA to unlock-A, 0x55 to unlock-B, then 0x30 to the sector address.
- R2: With `altUnlock`=0, unlock-A is word offset 0x555 and unlock-B is word offset 0x2AA. With `altUnlock`=1 they are 0x5555 and 0x2AAA. Each word offset is multiplied by `BUS_BYTES` and added to `bankBase`.
- R3: Sectors are processed in ascending order from `firstSect` to `lastSect`. The sector address of sector i is `bankBase` plus slice i (`ADDR_W` bits starting at bit i*`ADDR_W`) of `sectOffFlat`.
- R4: After each sector command, one status read is taken, then further reads follow. All status reads go to `bankBase`. If bit 6 is equal in the two most recent reads, the sector is complete and the block moves to the next sector.
- R5: Let the poll budget be T = `timeoutTicks`. If bit 6 has differed on T+1 consecutive compare reads of one sector, and the bit-5 path did not apply, the block ends with `errCode`=2 (busy) and reports that sector.
- R6: If bit 6 differs, bit 5 of the newer read is 1, and `dq5Enable`=1, the block takes two more reads. If bit 6 differs between them, it ends with `errCode`=1 (failed) and reports that sector. Otherwise the sector counts as complete.
- R7: With `dq5Enable`=0, bit 5 has no effect. A sector that keeps flipping bit 6 with bit 5 set ends as busy (`errCode`=2), not failed.
- R8: On a failed or busy sector, the block writes 0xF0 to `bankBase`, sets `failSect` to that sector and issues no command for later sectors.
- R9: When all sectors in the range complete, the block writes 0xF0 once to `bankBase` and finishes with `errCode`=0 and `failSect`=0.
- R10: A start with `lastSect` < `firstSect` or `lastSect` ≥ `NUM_SECT` issues no bus transfer. It raises `done` in the next cycle with `errCode`=3 and `failSect`=0.
- R11: `done` is a single-cycle pulse. `errCode` and `failSect` keep their values from that pulse until the next accepted start.
- R12: Once `busReq` is raised, `busAddr`, `busWe` and `busWdata` stay unchanged until the cycle in which `busAck` is seen.
- R13: After reset, `done`=0, `busReq`=0, `errCode`=0 and `failSect`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase run (accepted only when idle) |
| firstSect | input | IDX_W | First sector of the range |
| lastSect | input | IDX_W | Last sector of the range |
| bankBase | input | ADDR_W | Byte address of the bank |
| sectOffFlat | input | NUM_SECT*ADDR_W | Per-sector byte offsets from the bank base |
| altUnlock | input | 1 | Selects the long unlock offset pair |
| dq5Enable | input | 1 | Enables the bit-5 second-opinion check |
| timeoutTicks | input | TMO_W | Busy-read budget per sector |
| busReq | output | 1 | Flash transfer request |
| busWe | output | 1 | Transfer is a write |
| busAddr | output | ADDR_W | Transfer byte address |
| busWdata | output | 8 | Write data |
| busAck | input | 1 | Transfer accepted / read data valid |
| busRdata | input | 8 | Status byte read back |
| done | output | 1 | One-cycle end-of-run pulse |
| errCode | output | 2 | 0 ok, 1 failed, 2 busy, 3 bad range |
| failSect | output | IDX_W | Sector that ended the run on error |

## Verification
A bad-range start is due one cycle later: a start sampled at one edge gives `done` high after the next edge. The bench therefore checks `done`, `errCode` and `busReq` at the falling edge right after it drops `start`. A normal run takes a data-dependent number of cycles, so the bench waits for the `done` pulse and then reads `errCode`, `failSect` and its transfer logs in that same cycle. The reset write is acknowledged at the edge that enters the done cycle, so the logs are complete at that point. One falling edge later it checks that `done` has dropped, and ten cycles after that it checks that the results have held.

// File: rtl/sector_erase_pkg.sv
package sector_erase_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_FAIL  = 2'd1,
    ERR_BUSY  = 2'd2,
    ERR_RANGE = 2'd3
  } eraseErr_e;

  typedef enum logic [1:0] {
    BUS_CMD  = 2'd0,
    BUS_STAT = 2'd1,
    BUS_RST  = 2'd2
  } busKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      opInit;
    logic      cmdNext;
    logic      sectNext;
    logic      pollInit;
    logic      capOld;
    logic      capNew;
    logic      shiftOld;
    logic      tickStep;
    logic      waitArm;
    logic      errSet;
    eraseErr_e errVal;
    busKind_e  busKind;
  } eraseStb_t;

  localparam logic [7:0] OP_UNLOCK_A = 8'hAA;
  localparam logic [7:0] OP_UNLOCK_B = 8'h55;
  localparam logic [7:0] OP_SETUP    = 8'h80;
  localparam logic [7:0] OP_SECTOR   = 8'h30;
  localparam logic [7:0] OP_RESET    = 8'hF0;
  localparam int         CMD_STEPS   = 6;

endpackage

// File: rtl/sector_erase_dp.sv
module sector_erase_dp
  import sector_erase_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int NUM_SECT  = 8,
  parameter int IDX_W     = 4,
  parameter int BUS_BYTES = 2,
  parameter int TMO_W     = 16,
  parameter int POLL_GAP  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  eraseStb_t                  stb,
  input  logic [IDX_W-1:0]           firstSect,
  input  logic [IDX_W-1:0]           lastSect,
  input  logic [ADDR_W-1:0]          bankBase,
  input  logic [NUM_SECT*ADDR_W-1:0] sectOffFlat,
  input  logic                       altUnlock,
  input  logic                       dq5Enable,
  input  logic [TMO_W-1:0]           timeoutTicks,
  input  logic [7:0]                 busRdata,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [7:0]                 busWdata,
  output logic                       rangeBad,
  output logic                       cmdLast,
  output logic                       sectLast,
  output logic                       toggled,
  output logic                       dq5Hit,
  output logic                       tmoHit,
  output logic                       waitDone,
  output eraseErr_e                  errQ,
  output logic [IDX_W-1:0]           failQ
);

  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int WAIT_W = $clog2(POLL_GAP + 1);
  localparam int STEP_W = $clog2(CMD_STEPS);
  localparam logic [ADDR_W-1:0] UA_NEAR = ADDR_W'(32'h0555 * BUS_BYTES);
  localparam logic [ADDR_W-1:0] UB_NEAR = ADDR_W'(32'h02AA * BUS_BYTES);
  localparam logic [ADDR_W-1:0] UA_FAR  = ADDR_W'(32'h5555 * BUS_BYTES);
  localparam logic [ADDR_W-1:0] UB_FAR  = ADDR_W'(32'h2AAA * BUS_BYTES);

  logic [ADDR_W-1:0] sectOff [NUM_SECT];
  for (genvar g = 0; g < NUM_SECT; g++) begin : g_off
    assign sectOff[g] = sectOffFlat[g*ADDR_W +: ADDR_W];
  end

  logic [IDX_W-1:0]  curSect, lastQ;
  logic              altQ, dq5Q;
  logic [TMO_W-1:0]  tmoQ, tickQ;
  logic [STEP_W-1:0] stepQ;
  logic [7:0]        oldStat, newStat;
  logic [WAIT_W-1:0] waitQ;

  assign rangeBad = (lastSect < firstSect) || (lastSect >= IDX_W'(NUM_SECT));
  assign cmdLast  = (stepQ == STEP_W'(CMD_STEPS - 1));
  assign sectLast = (curSect == lastQ);
  assign toggled  = oldStat[6] ^ newStat[6];
  assign dq5Hit   = dq5Q & newStat[5];
  assign tmoHit   = (tickQ == tmoQ);
  assign waitDone = (waitQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSect <= '0;
      lastQ   <= '0;
      altQ    <= 1'b0;
      dq5Q    <= 1'b0;
      tmoQ    <= '0;
      stepQ   <= '0;
      oldStat <= '0;
      newStat <= '0;
      tickQ   <= '0;
      waitQ   <= '0;
      errQ    <= ERR_NONE;
      failQ   <= '0;
    end else begin
      if (stb.opInit) begin
        curSect <= firstSect;
        lastQ   <= lastSect;
        altQ    <= altUnlock;
        dq5Q    <= dq5Enable;
        tmoQ    <= timeoutTicks;
        stepQ   <= '0;
        errQ    <= ERR_NONE;
        failQ   <= '0;
      end
      if (stb.cmdNext)  stepQ   <= cmdLast ? '0 : stepQ + 1'b1;
      if (stb.sectNext) curSect <= curSect + 1'b1;
      if (stb.capOld)   oldStat <= busRdata;
      if (stb.capNew)   newStat <= busRdata;
      if (stb.shiftOld) oldStat <= newStat;
      if (stb.pollInit)      tickQ <= '0;
      else if (stb.tickStep) tickQ <= tickQ + 1'b1;
      if (stb.waitArm)        waitQ <= WAIT_W'(POLL_GAP - 1);
      else if (waitQ != '0)   waitQ <= waitQ - 1'b1;
      if (stb.errSet) begin
        errQ  <= stb.errVal;
        failQ <= (stb.errVal == ERR_RANGE) ? '0 : curSect;
      end
    end
  end

  logic [ADDR_W-1:0] unlockA, unlockB;
  assign unlockA = bankBase + (altQ ? UA_FAR : UA_NEAR);
  assign unlockB = bankBase + (altQ ? UB_FAR : UB_NEAR);

  always_comb begin
    busAddr  = bankBase;
    busWdata = '0;
    case (stb.busKind)
      BUS_CMD: begin
        case (stepQ)
          3'd0:    begin busAddr = unlockA; busWdata = OP_UNLOCK_A; end
          3'd1:    begin busAddr = unlockB; busWdata = OP_UNLOCK_B; end
          3'd2:    begin busAddr = unlockA; busWdata = OP_SETUP;    end
          3'd3:    begin busAddr = unlockA; busWdata = OP_UNLOCK_A; end
          3'd4:    begin busAddr = unlockB; busWdata = OP_UNLOCK_B; end
          default: begin
            busAddr  = bankBase + sectOff[curSect[SECT_W-1:0]];
            busWdata = OP_SECTOR;
          end
        endcase
      end
      BUS_RST: busWdata = OP_RESET;
      default: ;
    endcase
  end

endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
  import sector_erase_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      busAck,
  input  logic      rangeBad,
  input  logic      cmdLast,
  input  logic      sectLast,
  input  logic      toggled,
  input  logic      dq5Hit,
  input  logic      tmoHit,
  input  logic      waitDone,
  output eraseStb_t stb,
  output logic      busReq,
  output logic      busWe,
  output logic      done
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_RD_OLD, S_RD_NEW, S_EVAL, S_WAIT,
    S_RD_OLD2, S_RD_NEW2, S_EVAL2, S_RST, S_FIN
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb         = '0;
    stb.errVal  = ERR_NONE;
    stb.busKind = BUS_STAT;
    nextState   = state;
    case (state)
      S_IDLE: if (start) begin
        if (rangeBad) begin
          stb.errSet = 1'b1;
          stb.errVal = ERR_RANGE;
          nextState  = S_FIN;
        end else begin
          stb.opInit = 1'b1;
          nextState  = S_CMD;
        end
      end
      S_CMD: begin
        stb.busKind = BUS_CMD;
        if (busAck) begin
          stb.cmdNext = 1'b1;
          if (cmdLast) begin
            stb.pollInit = 1'b1;
            nextState    = S_RD_OLD;
          end
        end
      end
      S_RD_OLD: if (busAck) begin
        stb.capOld = 1'b1;
        nextState  = S_RD_NEW;
      end
      S_RD_NEW: if (busAck) begin
        stb.capNew = 1'b1;
        nextState  = S_EVAL;
      end
      S_EVAL: begin
        if (!toggled) begin
          if (sectLast) nextState = S_RST;
          else begin
            stb.sectNext = 1'b1;
            nextState    = S_CMD;
          end
        end else if (dq5Hit) begin
          nextState = S_RD_OLD2;
        end else if (tmoHit) begin
          stb.errSet = 1'b1;
          stb.errVal = ERR_BUSY;
          nextState  = S_RST;
        end else begin
          stb.tickStep = 1'b1;
          stb.shiftOld = 1'b1;
          stb.waitArm  = 1'b1;
          nextState    = S_WAIT;
        end
      end
      S_WAIT: if (waitDone) nextState = S_RD_NEW;
      S_RD_OLD2: if (busAck) begin
        stb.capOld = 1'b1;
        nextState  = S_RD_NEW2;
      end
      S_RD_NEW2: if (busAck) begin
        stb.capNew = 1'b1;
        nextState  = S_EVAL2;
      end
      S_EVAL2: begin
        if (toggled) begin
          stb.errSet = 1'b1;
          stb.errVal = ERR_FAIL;
          nextState  = S_RST;
        end else if (sectLast) begin
          nextState = S_RST;
        end else begin
          stb.sectNext = 1'b1;
          nextState    = S_CMD;
        end
      end
      S_RST: begin
        stb.busKind = BUS_RST;
        if (busAck) nextState = S_FIN;
      end
      S_FIN: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busReq = (state == S_CMD) || (state == S_RD_OLD) || (state == S_RD_NEW) ||
                  (state == S_RD_OLD2) || (state == S_RD_NEW2) || (state == S_RST);
  assign busWe  = (state == S_CMD) || (state == S_RST);
  assign done   = (state == S_FIN);

endmodule

// File: rtl/sector_eraser.sv
module sector_eraser
  import sector_erase_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int NUM_SECT  = 8,
  parameter int BUS_BYTES = 2,
  parameter int TMO_W     = 16,
  parameter int POLL_GAP  = 4,
  parameter int IDX_W     = $clog2(NUM_SECT) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [IDX_W-1:0]           firstSect,
  input  logic [IDX_W-1:0]           lastSect,
  input  logic [ADDR_W-1:0]          bankBase,
  input  logic [NUM_SECT*ADDR_W-1:0] sectOffFlat,
  input  logic                       altUnlock,
  input  logic                       dq5Enable,
  input  logic [TMO_W-1:0]           timeoutTicks,
  output logic                       busReq,
  output logic                       busWe,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [7:0]                 busWdata,
  input  logic                       busAck,
  input  logic [7:0]                 busRdata,
  output logic                       done,
  output logic [1:0]                 errCode,
  output logic [IDX_W-1:0]           failSect
);

  eraseStb_t stb;
  eraseErr_e errQ;
  logic rangeBad, cmdLast, sectLast, toggled, dq5Hit, tmoHit, waitDone;

  sector_erase_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busAck(busAck),
    .rangeBad(rangeBad), .cmdLast(cmdLast), .sectLast(sectLast),
    .toggled(toggled), .dq5Hit(dq5Hit), .tmoHit(tmoHit), .waitDone(waitDone),
    .stb(stb), .busReq(busReq), .busWe(busWe), .done(done)
  );

  sector_erase_dp #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .IDX_W(IDX_W),
    .BUS_BYTES(BUS_BYTES), .TMO_W(TMO_W), .POLL_GAP(POLL_GAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .firstSect(firstSect), .lastSect(lastSect), .bankBase(bankBase),
    .sectOffFlat(sectOffFlat), .altUnlock(altUnlock), .dq5Enable(dq5Enable),
    .timeoutTicks(timeoutTicks), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .rangeBad(rangeBad),
    .cmdLast(cmdLast), .sectLast(sectLast), .toggled(toggled), .dq5Hit(dq5Hit),
    .tmoHit(tmoHit), .waitDone(waitDone), .errQ(errQ), .failQ(failSect)
  );

  assign errCode = errQ;

endmodule

// File: rtl/sector_eraser_chk.sv
module sector_eraser_chk #(
  parameter int ADDR_W    = 24,
  parameter int NUM_SECT  = 8,
  parameter int BUS_BYTES = 2,
  parameter int TMO_W     = 16,
  parameter int POLL_GAP  = 4,
  parameter int IDX_W     = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic [IDX_W-1:0]           firstSect,
  input logic [IDX_W-1:0]           lastSect,
  input logic [ADDR_W-1:0]          bankBase,
  input logic                       altUnlock,
  input logic                       busReq,
  input logic                       busWe,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [7:0]                 busWdata,
  input logic                       busAck,
  input logic                       done,
  input logic [1:0]                 errCode,
  input logic [IDX_W-1:0]           failSect
);

  localparam logic [ADDR_W-1:0] SETUP_NEAR = ADDR_W'(32'h0555 * BUS_BYTES);
  localparam logic [ADDR_W-1:0] SETUP_FAR  = ADDR_W'(32'h5555 * BUS_BYTES);

  logic active, altSeen;
  logic badRange;
  assign badRange = (lastSect < firstSect) || (lastSect >= IDX_W'(NUM_SECT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      altSeen <= 1'b0;
    end else if (start && !active) begin
      active  <= 1'b1;
      altSeen <= altUnlock;
    end else if (done) begin
      active  <= 1'b0;
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !start) |=> ($stable(errCode) && $stable(failSect)));

  p_bad_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !active && badRange) |=> (done && errCode == 2'd3 && !busReq));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !busReq);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata)));

  p_reset_to_base_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && busWdata == 8'hF0) |-> busAddr == bankBase);

  p_setup_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && busWdata == 8'h80) |->
      busAddr == bankBase + (altSeen ? SETUP_FAR : SETUP_NEAR));

endmodule

bind sector_eraser sector_eraser_chk #(
  .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .BUS_BYTES(BUS_BYTES),
  .TMO_W(TMO_W), .POLL_GAP(POLL_GAP), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sector_eraser_tb.sv
`timescale 1ns/1ps
module sector_eraser_tb;

  localparam int ADDR_W    = 24;
  localparam int NUM_SECT  = 8;
  localparam int BUS_BYTES = 2;
  localparam int TMO_W     = 16;
  localparam int POLL_GAP  = 4;
  localparam int IDX_W     = 4;
  localparam logic [23:0] BANK = 24'h100000;
  localparam logic [23:0] SOFF = 24'h001000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0] firstSect = '0, lastSect = '0;
  logic [ADDR_W-1:0] bankBase = BANK;
  logic [NUM_SECT*ADDR_W-1:0] sectOffFlat;
  logic altUnlock = 1'b0, dq5Enable = 1'b0;
  logic [TMO_W-1:0] timeoutTicks = '0;
  logic busReq, busWe, busAck = 1'b0, done;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0] busWdata, busRdata = 8'h00;
  logic [1:0] errCode;
  logic [IDX_W-1:0] failSect;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_soff
    assign sectOffFlat[g*ADDR_W +: ADDR_W] = SOFF * g;
  end

  sector_eraser #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .BUS_BYTES(BUS_BYTES),
    .TMO_W(TMO_W), .POLL_GAP(POLL_GAP), .IDX_W(IDX_W)
  ) u_dut (.*);

  // flash status model: bit 6 flips after each read while busy reads remain
  logic [7:0] mdlBusy = 8'd0;
  logic       mdlDq5 = 1'b0;
  logic       tg = 1'b0;
  int         busyLeft = 0;

  always_ff @(posedge clk) begin
    busAck <= busReq && !busAck;
    if (busReq && !busAck && !busWe) begin
      busRdata <= {1'b0, tg, mdlDq5, 5'b0};
      if (busyLeft > 0) begin
        tg       <= ~tg;
        busyLeft <= busyLeft - 1;
      end
    end
    if (busReq && !busAck && busWe && busWdata == 8'h30) busyLeft <= int'(mdlBusy);
  end

  // bus logger
  logic [23:0] wAddr [64];
  logic [7:0]  wData [64];
  int wCnt = 0, rCnt = 0, rBad = 0, holdBad = 0;
  logic clrLog = 1'b0;
  logic prevPend = 1'b0, prevWe = 1'b0;
  logic [23:0] prevAddr = '0;
  logic [7:0]  prevWd = '0;

  always_ff @(posedge clk) begin
    if (clrLog) begin
      wCnt <= 0; rCnt <= 0; rBad <= 0;
    end else if (busReq && busAck) begin
      if (busWe) begin
        if (wCnt < 64) begin
          wAddr[wCnt] <= busAddr;
          wData[wCnt] <= busWdata;
        end
        wCnt <= wCnt + 1;
      end else begin
        rCnt <= rCnt + 1;
        if (busAddr != BANK) rBad <= rBad + 1;
      end
    end
    prevPend <= busReq && !busAck;
    prevAddr <= busAddr;
    prevWe   <= busWe;
    prevWd   <= busWdata;
    if (prevPend && (!busReq || busAddr != prevAddr || busWe != prevWe || busWdata != prevWd))
      holdBad <= holdBad + 1;
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  first;
    logic [3:0]  last;
    logic        alt;
    logic        en;
    logic        mode;
    logic [7:0]  busy;
    logic [15:0] tmo;
    logic [1:0]  err;
    logic [3:0]  fsect;
    logic [7:0]  nW;
    logic [7:0]  nR;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 8'd0,   16'd3,  2'd0, 4'd0, 8'd7,  8'd2},
    '{4'd1, 4'd3, 1'b0, 1'b0, 1'b0, 8'd2,   16'd4,  2'd0, 4'd0, 8'd19, 8'd12},
    '{4'd2, 4'd2, 1'b1, 1'b0, 1'b0, 8'd1,   16'd1,  2'd0, 4'd0, 8'd7,  8'd3},
    '{4'd4, 4'd5, 1'b0, 1'b0, 1'b0, 8'd3,   16'd2,  2'd2, 4'd4, 8'd7,  8'd4},
    '{4'd5, 4'd6, 1'b0, 1'b1, 1'b1, 8'd100, 16'd10, 2'd1, 4'd5, 8'd7,  8'd4},
    '{4'd6, 4'd7, 1'b0, 1'b1, 1'b1, 8'd1,   16'd5,  2'd0, 4'd0, 8'd13, 8'd8},
    '{4'd7, 4'd7, 1'b0, 1'b0, 1'b1, 8'd100, 16'd0,  2'd2, 4'd7, 8'd7,  8'd2},
    '{4'd3, 4'd2, 1'b0, 1'b0, 1'b0, 8'd0,   16'd3,  2'd3, 4'd0, 8'd0,  8'd0},
    '{4'd0, 4'd8, 1'b0, 1'b0, 1'b0, 8'd0,   16'd3,  2'd3, 4'd0, 8'd0,  8'd0},
    '{4'd0, 4'd7, 1'b1, 1'b0, 1'b0, 8'd0,   16'd0,  2'd0, 4'd0, 8'd49, 8'd16}
  };

  task automatic runVec(input vec_t v, input int idx);
    int k, stopS, waited;
    logic [23:0] ua, ub, ea;
    logic [7:0] ed;
    @(negedge clk);
    firstSect = v.first; lastSect = v.last; altUnlock = v.alt;
    dq5Enable = v.en; timeoutTicks = v.tmo; mdlBusy = v.busy; mdlDq5 = v.mode;
    clrLog = 1'b1;
    @(negedge clk);
    clrLog = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      chk($sformatf("vec %0d done never arrived", idx), 0, 1);
      return;
    end
    chk($sformatf("vec %0d R5 R6 R9 R10 errCode", idx), int'(errCode), int'(v.err));
    chk($sformatf("vec %0d R8 failSect", idx), int'(failSect), int'(v.fsect));
    chk($sformatf("vec %0d R8 R9 write count", idx), wCnt, int'(v.nW));
    chk($sformatf("vec %0d R4 R5 R6 R7 read count", idx), rCnt, int'(v.nR));
    chk($sformatf("vec %0d R4 status read address", idx), rBad, 0);
    // expected write sequence R1 R2 R3
    ua = BANK + (v.alt ? 24'h5555 : 24'h0555) * BUS_BYTES;
    ub = BANK + (v.alt ? 24'h2AAA : 24'h02AA) * BUS_BYTES;
    stopS = (v.err == 2'd0) ? int'(v.last) : int'(v.fsect);
    k = 0;
    if (v.err != 2'd3) begin
      for (int s = int'(v.first); s <= stopS; s++) begin
        for (int c = 0; c < 6; c++) begin
          case (c)
            0: begin ea = ua; ed = 8'hAA; end
            1: begin ea = ub; ed = 8'h55; end
            2: begin ea = ua; ed = 8'h80; end
            3: begin ea = ua; ed = 8'hAA; end
            4: begin ea = ub; ed = 8'h55; end
            default: begin ea = BANK + SOFF * s; ed = 8'h30; end
          endcase
          if (k < wCnt) begin
            chk($sformatf("vec %0d R1 R2 R3 write %0d addr", idx, k), int'(wAddr[k]), int'(ea));
            chk($sformatf("vec %0d R1 write %0d data", idx, k), int'(wData[k]), int'(ed));
          end
          k++;
        end
      end
      if (k < wCnt) begin
        chk($sformatf("vec %0d R8 R9 final reset addr", idx), int'(wAddr[k]), int'(BANK));
        chk($sformatf("vec %0d R8 R9 final reset data", idx), int'(wData[k]), 8'hF0);
      end
    end
    @(negedge clk);
    chk($sformatf("vec %0d R11 done single cycle", idx), int'(done), 0);
    repeat (10) @(negedge clk);
    chk($sformatf("vec %0d R11 errCode held", idx), int'(errCode), int'(v.err));
    chk($sformatf("vec %0d R11 failSect held", idx), int'(failSect), int'(v.fsect));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R13 reset state
    chk("R13 done after reset", int'(done), 0);
    chk("R13 busReq after reset", int'(busReq), 0);
    chk("R13 errCode after reset", int'(errCode), 0);
    chk("R13 failSect after reset", int'(failSect), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R13 idle bus after release", int'(busReq), 0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R10 bad range: done one cycle after start, no bus request
    @(negedge clk);
    firstSect = 4'd6; lastSect = 4'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done next cycle", int'(done), 1);
    chk("R10 errCode range", int'(errCode), 3);
    chk("R10 no bus request", int'(busReq), 0);
    @(negedge clk);
    chk("R10 R11 done dropped", int'(done), 0);

    // R12 request hold across every transfer seen
    chk("R12 request held until ack", holdBad, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule